// File: doc/BRIEF.md
# Audio Serial Port Clock Generator

This block makes the three timing references a serial audio port needs when it drives the link as master. Every cycle of the source clock is a candidate tick. A programmable prescaler thins these ticks into a root-clock strobe. A divider turns the root strobe into a bit clock whose period is a whole number of root ticks. A second divider turns the bit clock into a left/right frame clock with one full period per sample. All outputs are single-cycle strobes or levels in the source-clock domain, so downstream logic stays synchronous.

Software picks the ratios with 2-bit codes. The code values do not run in numeric order of the ratio. The generator refuses any combination it cannot produce exactly: a width/ratio pair that is not allowed, or a bit-clock ratio that does not divide the root ratio. In that case it raises an error flag and keeps every output idle. When the port is a slave, the far end supplies the clocks, so this block stays silent and ignores its ratio and prescaler settings.

Top module: `audio_clkgen`

## Requirements
- R1: While reset is asserted, and after reset while the global enable is low, `rclk_stb`, `bclk_stb`, `bclk_out`, `frame_out` and `cfg_err` are all 0.
- R2: With the prescaler enable low, `rclk_stb` is high on every source cycle while the block runs, whatever `psc_val` holds.
- R3: With the prescaler enable high, `rclk_stb` pulses once every `psc_val`+1 source cycles.
- R4: `rclk_code` selects a root ratio of 256 (code 0), 512 (code 1), 384 (code 2) or 768 (code 3) times the sample rate. `bclk_code` selects a bit ratio of 32 (0), 48 (1), 16 (2) or 24 (3). `bclk_stb` pulses once per bit period, and that period is (root ratio / bit ratio) root ticks.
- R5: `frame_out` toggles every (bit ratio / 2) bit periods. It is 0 in the first half of each frame after a start.
- R6: `bclk_out` is high for exactly half of each bit period. It falls in the cycle in which `bclk_stb` is high.
- R7: `width_code` means 16 bits (0), 8 bits (1) or 24 bits (2); code 3 is reserved. A 24-bit width with a root ratio of 256 or 512, or the reserved width code, sets `cfg_err` one cycle later and holds all clock outputs at 0. A 24-bit width with a root ratio of 384 or 768 is legal.
- R8: A root/bit ratio pair that does not divide evenly (for example 512/48 or 256/24) sets `cfg_err` and holds all clock outputs at 0.
- R9: With `slave_mode` high, every clock output stays 0 and `cfg_err` stays 0, even for an illegal ratio or width setting.
- R10: Dropping `glob_en` clears every divider, so all clock outputs are 0 after the next edge. After a restart with the prescaler bypassed, the first `bclk_stb` appears in cycle N+1 and `frame_out` first rises in cycle N·B/2+2. Here cycle 1 is the first edge that samples the enable high, N is the bit divide factor and B is the bit ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glob_en | input | 1 | Global enable; low clears all dividers |
| slave_mode | input | 1 | Port is slave; generator stays silent |
| psc_en | input | 1 | Prescaler enable; low passes the source through |
| psc_val | input | PSC_W | Prescaler value; divides by value+1 |
| rclk_code | input | 2 | Root clock ratio code |
| bclk_code | input | 2 | Bit clock ratio code |
| width_code | input | 2 | Sample width code |
| rclk_stb | output | 1 | Root clock tick strobe |
| bclk_stb | output | 1 | One-cycle strobe at the end of each bit period |
| bclk_out | output | 1 | Bit clock level |
| frame_out | output | 1 | Left/right frame clock level |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
Each stage adds one register, so the results arrive in a fixed order. After the edge that first samples the enable, `rclk_stb` is visible at once. `bclk_stb` follows N root ticks later. The frame edge comes one edge after the bit strobe that closes the half frame. `cfg_err` trails a configuration change by one edge. The bench changes configuration only with the enable low and lets two cycles pass before it looks. It samples at the falling edge. Period and duty checks start counting at a detected event, so they do not depend on start-up latency. The restart check instead counts edges from the enabling edge and compares the exact cycle numbers derived above.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

    localparam int RATIO_W = 10;

    function automatic logic [RATIO_W-1:0] root_ratio(input logic [1:0] code);
        case (code)
            2'd0:    return RATIO_W'(256);
            2'd1:    return RATIO_W'(512);
            2'd2:    return RATIO_W'(384);
            default: return RATIO_W'(768);
        endcase
    endfunction

    function automatic logic [RATIO_W-1:0] bit_ratio(input logic [1:0] code);
        case (code)
            2'd0:    return RATIO_W'(32);
            2'd1:    return RATIO_W'(48);
            2'd2:    return RATIO_W'(16);
            default: return RATIO_W'(24);
        endcase
    endfunction

    function automatic logic [4:0] sample_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd16;
            2'd1:    return 5'd8;
            2'd2:    return 5'd24;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/audio_clkgen_cfg.sv
module audio_clkgen_cfg
    import audio_clkgen_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slave_mode,
    input  logic [1:0]       rclk_code,
    input  logic [1:0]       bclk_code,
    input  logic [1:0]       width_code,
    output logic             bad_cfg,
    output logic [CNT_W-1:0] fac_n,
    output logic [CNT_W-1:0] fac_b,
    output logic             err_q
);
    logic [RATIO_W-1:0] rr;
    logic [RATIO_W-1:0] br;
    logic [RATIO_W-1:0] quot;
    logic               uneven;
    logic               wide_bad;
    logic               err_d;

    always_comb begin
        rr       = root_ratio(rclk_code);
        br       = bit_ratio(bclk_code);
        quot     = rr / br;
        uneven   = (rr % br) != '0;
        wide_bad = (sample_bits(width_code) == 5'd24) &&
                   ((rr == RATIO_W'(256)) || (rr == RATIO_W'(512)));
        bad_cfg  = uneven || wide_bad || (width_code == 2'd3);
        fac_n    = CNT_W'(quot);
        fac_b    = CNT_W'(br);
        err_d    = !slave_mode && bad_cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end
endmodule

// File: rtl/audio_clkgen_psc.sv
module audio_clkgen_psc #(
    parameter int PSC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             psc_en,
    input  logic [PSC_W-1:0] psc_val,
    output logic             tick
);
    typedef struct packed {
        logic [PSC_W-1:0] cnt;
        logic             stb;
    } psc_t;

    psc_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        st_d.cnt = '0;
        if (run) begin
            if (!psc_en) begin
                st_d.stb = 1'b1;
            end else if (st_q.cnt >= psc_val) begin
                st_d.stb = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.stb;
endmodule

// File: rtl/audio_clkgen_div.sv
module audio_clkgen_div #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] fac_n,
    input  logic [CNT_W-1:0] fac_b,
    output logic             bstb,
    output logic             bclk,
    output logic             frame
);
    typedef struct packed {
        logic [CNT_W-1:0] rcnt;
        logic [CNT_W-1:0] bcnt;
        logic             bclk;
        logic             bstb;
        logic             frame;
    } div_t;

    div_t dv_d, dv_q;
    logic [CNT_W-1:0] half_n;
    logic [CNT_W-1:0] half_b;

    assign half_n = fac_n >> 1;
    assign half_b = fac_b >> 1;

    always_comb begin
        dv_d      = dv_q;
        dv_d.bstb = 1'b0;
        if (!run) begin
            dv_d = '0;
        end else begin
            if (tick) begin
                if (dv_q.rcnt >= fac_n - 1'b1) begin
                    dv_d.rcnt = '0;
                    dv_d.bclk = 1'b0;
                    dv_d.bstb = 1'b1;
                end else begin
                    dv_d.rcnt = dv_q.rcnt + 1'b1;
                    if (dv_q.rcnt == half_n - 1'b1) dv_d.bclk = 1'b1;
                end
            end
            if (dv_q.bstb) begin
                if (dv_q.bcnt >= fac_b - 1'b1) begin
                    dv_d.bcnt  = '0;
                    dv_d.frame = ~dv_q.frame;
                end else begin
                    dv_d.bcnt = dv_q.bcnt + 1'b1;
                    if (dv_q.bcnt == half_b - 1'b1) dv_d.frame = ~dv_q.frame;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign bstb  = dv_q.bstb;
    assign bclk  = dv_q.bclk;
    assign frame = dv_q.frame;
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
    parameter int PSC_W   = 6,
    parameter int MAX_DIV = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glob_en,
    input  logic             slave_mode,
    input  logic             psc_en,
    input  logic [PSC_W-1:0] psc_val,
    input  logic [1:0]       rclk_code,
    input  logic [1:0]       bclk_code,
    input  logic [1:0]       width_code,
    output logic             rclk_stb,
    output logic             bclk_stb,
    output logic             bclk_out,
    output logic             frame_out,
    output logic             cfg_err
);
    localparam int CNT_W = $clog2(MAX_DIV + 1);

    logic             bad_cfg;
    logic [CNT_W-1:0] fac_n;
    logic [CNT_W-1:0] fac_b;
    logic             run;

    audio_clkgen_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .slave_mode (slave_mode),
        .rclk_code  (rclk_code),
        .bclk_code  (bclk_code),
        .width_code (width_code),
        .bad_cfg    (bad_cfg),
        .fac_n      (fac_n),
        .fac_b      (fac_b),
        .err_q      (cfg_err)
    );

    assign run = glob_en && !slave_mode && !bad_cfg;

    audio_clkgen_psc #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .psc_en  (psc_en),
        .psc_val (psc_val),
        .tick    (rclk_stb)
    );

    audio_clkgen_div #(.CNT_W(CNT_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (rclk_stb),
        .fac_n (fac_n),
        .fac_b (fac_b),
        .bstb  (bclk_stb),
        .bclk  (bclk_out),
        .frame (frame_out)
    );
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
    input logic clk,
    input logic rst_n,
    input logic glob_en,
    input logic slave_mode,
    input logic rclk_stb,
    input logic bclk_stb,
    input logic bclk_out,
    input logic frame_out,
    input logic cfg_err
);
    // R9
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |=> (!rclk_stb && !bclk_stb && !cfg_err));

    // R7
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!rclk_stb && !bclk_stb));

    // R10
    glob_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> (!rclk_stb && !bclk_stb && !bclk_out && !frame_out));

    // R6
    bclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_stb |-> !bclk_out);

    // R4
    bclk_from_root_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_stb |-> $past(rclk_stb));
endmodule

bind audio_clkgen audio_clkgen_chk u_audio_clkgen_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .glob_en    (glob_en),
    .slave_mode (slave_mode),
    .rclk_stb   (rclk_stb),
    .bclk_stb   (bclk_stb),
    .bclk_out   (bclk_out),
    .frame_out  (frame_out),
    .cfg_err    (cfg_err)
);

// File: tb/audio_clkgen_bench.sv
module audio_clkgen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       glob_en = 1'b0;
    logic       slave_mode = 1'b0;
    logic       psc_en = 1'b0;
    logic [5:0] psc_val = '0;
    logic [1:0] rclk_code = '0;
    logic [1:0] bclk_code = '0;
    logic [1:0] width_code = '0;
    logic       rclk_stb, bclk_stb, bclk_out, frame_out, cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    audio_clkgen u_audio_clkgen (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .slave_mode(slave_mode),
        .psc_en(psc_en), .psc_val(psc_val), .rclk_code(rclk_code),
        .bclk_code(bclk_code), .width_code(width_code), .rclk_stb(rclk_stb),
        .bclk_stb(bclk_stb), .bclk_out(bclk_out), .frame_out(frame_out),
        .cfg_err(cfg_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic sig(input int sel);
        case (sel)
            0:       return rclk_stb;
            1:       return bclk_stb;
            default: return bclk_out;
        endcase
    endfunction

    // cycles between two consecutive high samples of a strobe (sel 0/1)
    task automatic period(input int sel, output int per);
        int n = 0;
        per = -1;
        while (!sig(sel) && n < 20000) begin @(negedge clk); n++; end
        n = 0;
        do begin @(negedge clk); n++; end while (!sig(sel) && n < 20000);
        if (n < 20000) per = n;
    endtask

    // high cycles of bclk_out in one period, starting at its rise
    task automatic high_len(output int len);
        int n = 0;
        len = -1;
        while (bclk_out && n < 20000) begin @(negedge clk); n++; end
        while (!bclk_out && n < 20000) begin @(negedge clk); n++; end
        len = 0;
        while (bclk_out && n < 20000) begin @(negedge clk); n++; len++; end
    endtask

    // cycles between two frame toggles
    task automatic frame_half(output int per);
        logic prev;
        int n = 0;
        prev = frame_out;
        while (frame_out == prev && n < 20000) begin @(negedge clk); n++; end
        prev = frame_out;
        per = 0;
        while (frame_out == prev && n < 40000) begin @(negedge clk); n++; per++; end
    endtask

    task automatic setup(input logic [1:0] rc, input logic [1:0] bc, input logic [1:0] wc,
                         input logic pe, input logic [5:0] pv, input logic sl);
        @(negedge clk);
        glob_en = 1'b0;
        @(negedge clk);
        rclk_code = rc; bclk_code = bc; width_code = wc;
        psc_en = pe; psc_val = pv; slave_mode = sl;
        @(negedge clk);
        @(negedge clk);
        glob_en = 1'b1;
    endtask

    task automatic idle_count(input int cycles, output int hits);
        hits = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (rclk_stb || bclk_stb || bclk_out || frame_out) hits++;
        end
    endtask

    task automatic t_reset();
        #1;
        check("R1 outputs in reset", {rclk_stb, bclk_stb, bclk_out, frame_out, cfg_err}, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 outputs enable low", {rclk_stb, bclk_stb, bclk_out, frame_out, cfg_err}, 0);
    endtask

    task automatic t_bypass();
        int p;
        setup(2'd0, 2'd0, 2'd0, 1'b0, 6'd9, 1'b0);
        repeat (3) @(negedge clk);
        period(0, p);
        check("R2 root period bypass", p, 1);
        check("R2 root high each cycle", rclk_stb, 1);
    endtask

    task automatic t_psc();
        int p;
        setup(2'd0, 2'd0, 2'd0, 1'b1, 6'd3, 1'b0);
        period(0, p);
        check("R3 root period val 3", p, 4);
        period(1, p);
        check("R3 bit period with prescale", p, 32);
        setup(2'd0, 2'd0, 2'd0, 1'b1, 6'd0, 1'b0);
        period(0, p);
        check("R3 root period val 0", p, 1);
    endtask

    task automatic t_ratio(input logic [1:0] rc, input logic [1:0] bc, input int n, input int b);
        int p;
        setup(rc, bc, 2'd0, 1'b0, 6'd0, 1'b0);
        period(1, p);
        check($sformatf("R4 bit period rc%0d bc%0d", rc, bc), p, n);
        high_len(p);
        check($sformatf("R6 bit high rc%0d bc%0d", rc, bc), p, n / 2);
        frame_half(p);
        check($sformatf("R5 frame half rc%0d bc%0d", rc, bc), p, n * b / 2);
        check("R7 no error legal", cfg_err, 0);
    endtask

    task automatic t_illegal();
        int h;
        setup(2'd0, 2'd0, 2'd2, 1'b0, 6'd0, 1'b0);
        check("R7 err 24b at 256", cfg_err, 1);
        idle_count(100, h);
        check("R7 idle 24b at 256", h, 0);
        setup(2'd1, 2'd0, 2'd2, 1'b0, 6'd0, 1'b0);
        check("R7 err 24b at 512", cfg_err, 1);
        setup(2'd0, 2'd0, 2'd3, 1'b0, 6'd0, 1'b0);
        check("R7 err reserved width", cfg_err, 1);
        setup(2'd2, 2'd1, 2'd2, 1'b0, 6'd0, 1'b0);
        check("R7 no err 24b at 384", cfg_err, 0);
        idle_count(20, h);
        check("R7 runs 24b at 384", h > 0, 1);
    endtask

    task automatic t_nonint();
        int h;
        setup(2'd1, 2'd1, 2'd0, 1'b0, 6'd0, 1'b0);
        check("R8 err 512/48", cfg_err, 1);
        idle_count(100, h);
        check("R8 idle 512/48", h, 0);
        setup(2'd0, 2'd3, 2'd1, 1'b0, 6'd0, 1'b0);
        check("R8 err 256/24", cfg_err, 1);
    endtask

    task automatic t_slave();
        int h;
        setup(2'd1, 2'd1, 2'd2, 1'b1, 6'd2, 1'b1);
        idle_count(200, h);
        check("R9 slave silent", h, 0);
        check("R9 slave no error", cfg_err, 0);
        slave_mode = 1'b0;
    endtask

    task automatic t_restart();
        int first_b = -1;
        int first_f = -1;
        setup(2'd0, 2'd0, 2'd0, 1'b0, 6'd0, 1'b0);
        repeat (300) @(negedge clk);
        glob_en = 1'b0;
        @(negedge clk);
        check("R10 cleared after drop", {rclk_stb, bclk_stb, bclk_out, frame_out}, 0);
        @(negedge clk);
        glob_en = 1'b1;
        for (int i = 1; i <= 400; i++) begin
            @(negedge clk);
            if (bclk_stb && first_b < 0) first_b = i;
            if (frame_out && first_f < 0) first_f = i;
        end
        check("R10 first bit strobe cycle", first_b, 9);
        check("R10 first frame rise cycle", first_f, 130);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_bypass();
        t_psc();
        t_ratio(2'd0, 2'd0, 8, 32);
        t_ratio(2'd1, 2'd2, 32, 16);
        t_ratio(2'd2, 2'd1, 8, 48);
        t_ratio(2'd3, 2'd3, 32, 24);
        t_ratio(2'd2, 2'd0, 12, 32);
        t_ratio(2'd3, 2'd2, 48, 16);
        t_illegal();
        t_nonint();
        t_slave();
        t_restart();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule